// File: doc/BRIEF.md
# Byte-Serial Dual-Width CRC Engine

This block computes a running cyclic redundancy check over a byte stream that software feeds through a register strobe, one byte per write. The polynomial width is chosen at run time: a 32-bit generator (0x04C11DB7) or a 16-bit generator (0x1021). Each byte is folded into the running value in the clock edge that accepts the write. The update works least-significant bit first on the bit-reflected generator (0xEDB88320 or 0x8408). The result is kept as it stands, with no final inversion. With a starting value of all ones this reproduces the usual check values, for example 0x63 gives 0xF9462090.

A control write does three things. Bit 0 selects the width (0 = 32-bit, 1 = 16-bit). Bit 1 picks the start value (0 = all zeros, 1 = all ones). Bit 2, when set, loads that start value straight away. The running value is reached one byte at a time through a data port. A two-bit byte pointer picks the byte, where pointer 0 is bits 7:0. The pointer moves on after every read strobe or write strobe on that port.

Top module: `crc_bytewise`

## Requirements
- R1: In 32-bit mode each accepted input byte updates the result with generator 0x04C11DB7, processed LSB first in reflected form (0xEDB88320) with no final XOR. From all ones, 0x63 gives 0xF9462090, AA BB CC gives 0x41B207B3 and 00 00 AA BB CC gives 0x78D129BC.
- R2: In 16-bit mode (control bit 0 = 1) the update uses generator 0x1021 in reflected form (0x8408) on the low 16 bits only, and bits 31:16 stay zero.
- R3: A control write with bit 2 set loads the start value, which is zero when bit 1 = 0. When bit 1 = 1 it is 0xFFFFFFFF in 32-bit mode or 0x0000FFFF in 16-bit mode. The width and start value written in that same control write take effect for the load. A control write with bit 2 clear leaves the result unchanged.
- R4: A strobe on `din_we` folds `wdata` into the result. The new value is visible on `rdata` after the next rising clock edge.
- R5: `rdata` always shows the result byte chosen by the pointer. Pointer value k selects bits 8k+7:8k.
- R6: Every strobe on `dat_re` or `dat_we` advances the pointer. It wraps from 3 to 0 in 32-bit mode and from 1 to 0 in 16-bit mode.
- R7: The pointer returns to 0 on a load (R3) and on reset.
- R8: A strobe on `dat_we` replaces the result byte at the pointer with `wdata`.
- R9: Without a load, a data-port write or an input byte, the result holds its value.
- R10: In 16-bit mode, `rdata` reads 0 whenever the pointer is 2 or 3.
- R11: Strobes in the same cycle follow a fixed priority. A load beats a data-port write, and a data-port write beats an input byte. The losing input byte is dropped.
- R12: After reset the result is zero, the mode is 32-bit and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdata | input | 8 | Write data shared by all three write strobes |
| ctl_we | input | 1 | Control write: bit 0 width, bit 1 start value, bit 2 load |
| din_we | input | 1 | Input byte strobe |
| dat_we | input | 1 | Result byte write strobe |
| dat_re | input | 1 | Result byte read strobe (advances the pointer) |
| rdata | output | 8 | Result byte selected by the pointer |

## Verification
The checker watches the register behaviour on every cycle. It confirms that a load produces the right start value and clears the pointer. It confirms that each data-port access moves the pointer by one and wraps it for the current width, that a byte write lands in the lane it addressed, that the result holds when nothing touches it, and that the upper lanes read zero in 16-bit mode. What the checker cannot show is whether the CRC arithmetic itself is right. That needs the bench's byte streams: the published 32-bit check values, plus 16-bit and zero-start streams compared with a bitwise model. Strobe collisions, pointer wrap seen through the data, and a control write that must not load are also shown only by the bench's directed scenarios.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int RES_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NLANE  = RES_W / BYTE_W;
  localparam int PTR_W  = $clog2(NLANE);
  localparam int HALF_W = 16;
  localparam int HLANE  = HALF_W / BYTE_W;

  // Reflected generators (LSB-first processing)
  localparam logic [RES_W-1:0] RPOLY_WIDE = 32'hEDB8_8320; // 0x04C11DB7
  localparam logic [RES_W-1:0] RPOLY_HALF = 32'h0000_8408; // 0x1021

  // Control write field positions
  localparam int CTL_HALF = 0;
  localparam int CTL_ONES = 1;
  localparam int CTL_LOAD = 2;

  function automatic logic [RES_W-1:0] width_mask(input logic half);
    width_mask = half ? {{(RES_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {RES_W{1'b1}};
  endfunction
endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input  logic [W-1:0]  crc_i,
  input  logic [BW-1:0] byte_i,
  input  logic [W-1:0]  rpoly_i,
  output logic [W-1:0]  crc_o
);
  logic [BW:0][W-1:0] stage;

  assign stage[0] = crc_i ^ {{(W-BW){1'b0}}, byte_i};

  for (genvar g = 0; g < BW; g++) begin : g_bit
    assign stage[g+1] = (stage[g] >> 1) ^ (stage[g][0] ? rpoly_i : '0);
  end

  assign crc_o = stage[BW];
endmodule

// File: rtl/crc_byte_ptr.sv
module crc_byte_ptr #(
  parameter int PTR_W = 2,
  parameter int HLANE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             half_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST_WIDE = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] LAST_HALF = PTR_W'(HLANE - 1);

  logic [PTR_W-1:0] ptr_q, ptr_n, last;
  logic             ptr_en;

  always_comb begin
    last   = half_i ? LAST_HALF : LAST_WIDE;
    ptr_en = clr_i | adv_i;
    if (clr_i)              ptr_n = '0;
    else if (ptr_q == last) ptr_n = '0;
    else                    ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/crc_bytewise.sv
module crc_bytewise
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ctl_we,
  input  logic              din_we,
  input  logic              dat_we,
  input  logic              dat_re,
  output logic [BYTE_W-1:0] rdata
);
  logic             rst_n_s;
  logic [RES_W-1:0] res_q, res_n, step_out, lane_wr, start_val, mask_q, rpoly;
  logic             half_q, half_n, ones_q, ones_n;
  logic             load_go, res_en, cfg_en;
  logic [PTR_W-1:0] ptr;
  logic [NLANE-1:0][BYTE_W-1:0] lanes;

  crc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  crc_byte_ptr #(.PTR_W(PTR_W), .HLANE(HLANE)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .clr_i(load_go),
    .adv_i(dat_we | dat_re), .half_i(half_q), .ptr_o(ptr)
  );

  assign mask_q = width_mask(half_q);
  assign rpoly  = half_q ? RPOLY_HALF : RPOLY_WIDE;

  crc_byte_step #(.W(RES_W), .BW(BYTE_W)) u_step (
    .crc_i(res_q & mask_q), .byte_i(wdata), .rpoly_i(rpoly), .crc_o(step_out)
  );

  // Byte lanes of the held result, masked to the active width
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign lanes[l] = res_q[l*BYTE_W +: BYTE_W] & mask_q[l*BYTE_W +: BYTE_W];
    assign lane_wr[l*BYTE_W +: BYTE_W] =
      (ptr == PTR_W'(l)) ? wdata : res_q[l*BYTE_W +: BYTE_W];
  end

  assign rdata = lanes[ptr];

  // Configuration next state
  always_comb begin
    cfg_en    = ctl_we;
    half_n    = wdata[CTL_HALF];
    ones_n    = wdata[CTL_ONES];
    load_go   = ctl_we & wdata[CTL_LOAD];
    start_val = ones_n ? width_mask(half_n) : '0;
  end

  // Result next state: load > byte write > input byte
  always_comb begin
    res_en = load_go | dat_we | din_we;
    if (load_go)     res_n = start_val;
    else if (dat_we) res_n = lane_wr & mask_q;
    else             res_n = step_out & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      half_q <= 1'b0;
      ones_q <= 1'b0;
    end else if (cfg_en) begin
      half_q <= half_n;
      ones_q <= ones_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    res_q <= '0;
    else if (res_en) res_q <= res_n;
  end

  logic unused_ones;
  assign unused_ones = ones_q;
endmodule

// File: rtl/crc_bytewise_chk.sv
module crc_bytewise_chk
  import crc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] wdata,
  input logic              ctl_we,
  input logic              din_we,
  input logic              dat_we,
  input logic              dat_re,
  input logic [BYTE_W-1:0] rdata,
  input logic [RES_W-1:0]  res,
  input logic              half,
  input logic [PTR_W-1:0]  ptr
);
  logic load;
  assign load = ctl_we & wdata[CTL_LOAD];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p, input logic h);
    if (h && p == PTR_W'(HLANE - 1)) next_ptr = '0;
    else                             next_ptr = p + 1'b1;
  endfunction

  function automatic logic [RES_W-1:0] start_of(input logic [BYTE_W-1:0] w);
    if (!w[CTL_ONES])     start_of = '0;
    else if (w[CTL_HALF]) start_of = 32'h0000_FFFF;
    else                  start_of = 32'hFFFF_FFFF;
  endfunction

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> res == start_of($past(wdata))); // R3

  AST_LOAD_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == '0); // R7

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (dat_we || dat_re) && !ctl_we) |=> ptr == next_ptr($past(ptr), $past(half))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dat_we && !din_we) |=> $stable(res)); // R9

  AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (half && ptr[PTR_W-1]) |-> rdata == '0); // R10

  AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !load && !half) |=> BYTE_W'(res >> {$past(ptr), 3'b000}) == $past(wdata)); // R8
endmodule

bind crc_bytewise crc_bytewise_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .wdata(wdata), .ctl_we(ctl_we), .din_we(din_we),
  .dat_we(dat_we), .dat_re(dat_re), .rdata(rdata), .res(res_q), .half(half_q), .ptr(ptr)
);

// File: tb/crc_bytewise_tb.sv
module crc_bytewise_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wdata;
  logic       ctl_we, din_we, dat_we, dat_re;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  crc_bytewise u_dut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctl_we(ctl_we), .din_we(din_we),
    .dat_we(dat_we), .dat_re(dat_re), .rdata(rdata)
  );

  typedef struct packed {
    logic        half;
    logic        ones;
    logic [2:0]  len;
    logic [39:0] bytes;   // first byte in bits 39:32
    logic        known;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 3'd1, 40'h63_0000_0000, 1'b1, 32'hF946_2090},
    '{1'b0, 1'b1, 3'd3, 40'hAA_BBCC_0000, 1'b1, 32'h41B2_07B3},
    '{1'b0, 1'b1, 3'd5, 40'h00_00AA_BBCC, 1'b1, 32'h78D1_29BC},
    '{1'b0, 1'b0, 3'd4, 40'h12_3456_7800, 1'b0, 32'h0},
    '{1'b1, 1'b1, 3'd3, 40'hAA_BBCC_0000, 1'b0, 32'h0},
    '{1'b1, 1'b0, 3'd2, 40'h55_8000_0000, 1'b0, 32'h0},
    '{1'b1, 1'b1, 3'd1, 40'h63_0000_0000, 1'b0, 32'h0},
    '{1'b0, 1'b0, 3'd1, 40'h00_0000_0000, 1'b1, 32'h0}
  };

  // Bitwise model written from R1/R2
  function automatic logic [31:0] model_byte(input logic [31:0] c, input logic [7:0] b,
                                             input logic h);
    logic [31:0] p;
    logic [31:0] r;
    p = h ? 32'h0000_8408 : 32'hEDB8_8320;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
    model_byte = h ? (r & 32'h0000_FFFF) : r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic h, input logic o, input logic go);
    wdata = {5'b0, go, o, h}; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    wdata = b; din_we = 1'b1;
    @(negedge clk); din_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    wdata = b; dat_we = 1'b1;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic get(input int n, output logic [31:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      r = r | (32'(rdata) << (8 * i));
      dat_re = 1'b1;
      @(negedge clk); dat_re = 1'b0;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, m, first;
    rst_n = 1'b0; wdata = '0; ctl_we = 0; din_we = 0; dat_we = 0; dat_re = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state, read through the port from pointer 0
    get(4, r);
    check(r == 32'h0, "R12 reset result", r, 32'h0);

    // Vector table: R1, R2, R3, R4, R5, R9
    for (int v = 0; v < NV; v++) begin
      ctl(VECS[v].half, VECS[v].ones, 1'b1);
      m = VECS[v].ones ? (VECS[v].half ? 32'h0000_FFFF : 32'hFFFF_FFFF) : 32'h0;
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        logic [7:0] b;
        b = VECS[v].bytes[39 - 8*i -: 8];
        feed(b);
        m = model_byte(m, b, VECS[v].half);
      end
      get(VECS[v].half ? 2 : 4, r);
      check(r == m, VECS[v].half ? "R2 16-bit model" : "R1 32-bit model", r, m);
      if (VECS[v].known) check(r == VECS[v].exp, "R1 check value", r, VECS[v].exp);
      repeat (4) @(negedge clk);
      get(VECS[v].half ? 2 : 4, first);
      check(first == m, "R9 hold after idle", first, m);
    end

    // R3: control write without load leaves the result alone
    ctl(1'b0, 1'b1, 1'b1);
    feed(8'h63);
    ctl(1'b0, 1'b0, 1'b0);
    get(4, r);
    check(r == 32'hF946_2090, "R3 no load without bit 2", r, 32'hF946_2090);

    // R8/R5: byte writes in 32-bit mode, then R6 wrap 3->0
    ctl(1'b0, 1'b0, 1'b1);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    get(4, r);
    check(r == 32'h4433_2211, "R8 byte writes", r, 32'h4433_2211);
    get(1, r);
    check(r == 32'h11, "R6 wrap 32-bit", r, 32'h11);

    // R6: 16-bit wrap 1->0 seen through the data
    ctl(1'b1, 1'b0, 1'b1);
    put(8'hA1); put(8'hB2); put(8'hC3); put(8'hD4);
    get(2, r);
    check(r == 32'h0000_D4C3, "R6 wrap 16-bit", r, 32'h0000_D4C3);

    // R10: upper lanes read zero in 16-bit mode
    ctl(1'b0, 1'b1, 1'b1);
    get(2, r);                       // pointer now 2
    ctl(1'b1, 1'b1, 1'b0);           // switch width, no load
    check(rdata == 8'h00, "R10 upper lane zero", {24'h0, rdata}, 32'h0);

    // R11/R7: load wins over byte write and input byte
    ctl(1'b0, 1'b1, 1'b1);           // 0xFFFFFFFF
    get(1, r);                       // pointer 1
    wdata = 8'b0000_0100; ctl_we = 1; dat_we = 1; din_we = 1;
    @(negedge clk); ctl_we = 0; dat_we = 0; din_we = 0;
    get(4, r);
    check(r == 32'h0, "R11 load wins, R7 pointer cleared", r, 32'h0);

    // R11: byte write wins over input byte (pointer 0 -> lane 0, pointer -> 1)
    wdata = 8'h5A; dat_we = 1; din_we = 1;
    @(negedge clk); dat_we = 0; din_we = 0;
    get(4, r);                       // reads lanes 1,2,3,0
    check(r == 32'h5A00_0000, "R11 byte write beats input", r, 32'h5A00_0000);

    // R4: update visible right after one edge
    ctl(1'b0, 1'b1, 1'b1);
    feed(8'h63);
    check(rdata == 8'h90, "R4 next-edge update", {24'h0, rdata}, 32'h90);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule